// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a simple on-chip request port to an 8-bit external memory or peripheral bus. On that bus the low address byte and the data byte share one tri-stated set of lines, and an external transparent latch captures the low address. A single-cycle pulse on the address latch strobe tells the latch when to capture. The high address byte has dedicated lines, and the number of those lines the block actually drives is configurable. Read and write strobes are active low.

Each accepted request is classified by its address. Addresses at or below the top of internal memory are internal. The block only reports a hit for those and never pulses the strobes. Higher addresses go to the external bus. The external space is split into a lower and an upper sector at a boundary set by a three-bit limit. Each sector has its own two-bit wait code, and every wait step lengthens the cycle by one clock. A compatibility setting reduces the block to a single sector with two wait settings. In that setting the full high byte is driven and the bus keeper is off. When the block is disabled, it releases every pin and answers requests at once without mapping anything.

The requester holds `req_valid` and the request fields steady until `req_ready` has been high for one clock. `req_rdata` is valid in that clock.

Top module: `xbus_ctrl`

## Requirements
- R1: `int_hit` is high exactly when `req_valid` is high and `req_addr` is at or below 0x10FF.
- R2: The clock after a request is accepted is period T1. With the block enabled, `req_ready` is high only in period T(4+w) and for exactly one clock. Here w is the selected wait code, and w is taken as 0 for internal addresses.
- R3: During T1 and only then, `ale_o` is high, `ad_oe` is high, and `ad_o` equals the low address byte. Throughout the cycle `hi_addr_o` equals the high address byte with the released bits zeroed.
- R4: For an external write, `ad_oe` stays high from T2 to the end with `ad_o` equal to the write data. `wr_n_o` is low in periods T3 through T(3+w), which is 1+w clocks.
- R5: For an external read, `ad_oe` is low from T2 on and `rd_n_o` is low in T3 through T(3+w). `req_rdata` returns `ad_i` as sampled on the edge where `rd_n_o` rises.
- R6: The lower sector code `cfg_wait_lo` applies when `cfg_limit` is nonzero and the address is below `cfg_limit`×0x2000. In every other case `cfg_wait_hi` applies.
- R7: An internal access with the block enabled runs four periods with the ALE pulse and the address on the bus. The strobes stay high and `req_rdata` is 0.
- R8: Bit k of `hi_oe` is 1 exactly when the block is enabled and k < `cfg_hi_width`. A width of 8 or more drives all bits.
- R9: `keeper_o` is high when the block is enabled, compatibility is off, `cfg_keeper_en` is set and `ad_oe` is low. Whenever `ad_oe` is low, `ad_o` holds the last value the block drove.
- R10: With `cfg_compat` set, the wait code is {0, `cfg_wait_hi`[0]} for every external address. All eight high bits are driven and `keeper_o` stays low.
- R11: With `cfg_enable` low, `ale_o` stays low, both strobes stay high, and `ad_oe` and `hi_oe` stay 0. The request then completes one clock after acceptance with `req_rdata` equal to 0.
- R12: No request is accepted while a cycle is in progress. The next request is accepted only after the clock in which `req_ready` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Interface enable |
| cfg_compat | input | 1 | Compatibility (reduced) mode |
| cfg_keeper_en | input | 1 | Bus keeper enable |
| cfg_limit | input | 3 | Sector boundary in units of 0x2000; 0 means a single sector |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_hi_width | input | 4 | Number of high address bits driven |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Read data |
| int_hit | output | 1 | Request targets internal memory |
| ad_o | output | 8 | Shared address/data bus, output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus, input value |
| hi_addr_o | output | 8 | High address byte |
| hi_oe | output | 8 | Per-bit enable of the high address lines |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| keeper_o | output | 1 | Bus keeper active |

## Verification
The bench sweeps every boundary limit against every pair of sector codes. It probes the addresses just at and around both the internal top and the sector boundary, where an off-by-one compare would pick the wrong code and shift the ready pulse and the strobe length by a clock. The read model returns the complement of the data except while the read strobe is low. A design that samples one edge late therefore returns inverted data. A design that drives the bus during a read, or lets the address leave the bus before the latch strobe falls, is caught by the cycle-by-cycle bus checks. The high width sweep, compatibility mode and the disabled block each have their own passes, which catch wrong output-enable masks, a keeper left on, or bus activity while the block is released.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RUN  = 2'd1,
        M_DONE = 2'd2
    } mode_e;

    localparam int BASE_PERIODS = 4;
    localparam int FIRST_STROBE = 3;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INT_TOP    = 16'h10FF,
    parameter int          SECT_SHIFT = 13,
    parameter int          LIMIT_W    = 3,
    parameter int          WAIT_W     = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [WAIT_W-1:0]  wait_lo,
    input  logic [WAIT_W-1:0]  wait_hi,
    input  logic               compat,
    output logic               is_ext,
    output logic [WAIT_W-1:0]  wait_code
);
    logic [ADDR_W-1:0] boundary;
    logic              in_lower;

    always_comb begin
        is_ext    = addr > ADDR_W'(INT_TOP);
        boundary  = ADDR_W'(limit) << SECT_SHIFT;
        in_lower  = !compat && (limit != '0) && (addr < boundary);
        if (compat)
            wait_code = WAIT_W'(wait_hi[0]);
        else if (in_lower)
            wait_code = wait_lo;
        else
            wait_code = wait_hi;
    end
endmodule

// File: rtl/xbus_himask.sv
module xbus_himask #(
    parameter int HI_W = 8,
    parameter int WID_W = 4
) (
    input  logic             enable,
    input  logic             compat,
    input  logic [WID_W-1:0] width,
    output logic [HI_W-1:0]  mask
);
    for (genvar k = 0; k < HI_W; k++) begin : g_bit
        assign mask[k] = enable && (compat || (width > WID_W'(k)));
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     is_ext,
    input  logic [WAIT_W-1:0]        wait_code,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     ready,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);
    localparam int LAST_MAX = BASE_PERIODS + (1 << WAIT_W) - 1;
    localparam int CNT_W    = $clog2(LAST_MAX + 1);

    typedef struct packed {
        mode_e              mode;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   last;
        logic               wr;
        logic               ext;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [DATA_W-1:0]  held;
    } st_t;

    st_t q, d;
    logic run, t1, strobe;
    logic [DATA_W-1:0] drv;

    always_comb begin
        d      = q;
        run    = q.mode == M_RUN;
        t1     = run && (q.cnt == CNT_W'(1));
        strobe = run && q.ext && (q.cnt >= CNT_W'(FIRST_STROBE)) && (q.cnt < q.last);
        ad_oe  = t1 || (run && q.wr);
        drv    = t1 ? q.addr[DATA_W-1:0] : q.wdata;
        ad_o   = ad_oe ? drv : q.held;
        ale    = t1;
        rd_n   = !(strobe && !q.wr);
        wr_n   = !(strobe && q.wr);
        ready  = (run && (q.cnt == q.last)) || (q.mode == M_DONE);
        rdata  = q.rdata;
        addr_hi = q.addr[ADDR_W-1:DATA_W];

        if (ad_oe)
            d.held = drv;

        case (q.mode)
            M_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.wr    = req_write;
                    d.rdata = '0;
                    d.ext   = is_ext;
                    d.cnt   = CNT_W'(1);
                    d.last  = is_ext ? CNT_W'(BASE_PERIODS) + CNT_W'(wait_code)
                                     : CNT_W'(BASE_PERIODS);
                    d.mode  = enable ? M_RUN : M_DONE;
                end
            end
            M_RUN: begin
                if (strobe && !q.wr && (q.cnt == q.last - CNT_W'(1)))
                    d.rdata = ad_i;
                if (q.cnt == q.last)
                    d.mode = M_IDLE;
                else
                    d.cnt = q.cnt + CNT_W'(1);
            end
            default: d.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r2_ready_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    a_r3_ale_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);
    a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (q.cnt != q.last)) |=> (q.mode == M_RUN));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [15:0] INT_TOP    = 16'h10FF,
    parameter int          SECT_SHIFT = 13,
    parameter int          LIMIT_W    = 3,
    parameter int          WAIT_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_enable,
    input  logic                          cfg_compat,
    input  logic                          cfg_keeper_en,
    input  logic [LIMIT_W-1:0]            cfg_limit,
    input  logic [WAIT_W-1:0]             cfg_wait_lo,
    input  logic [WAIT_W-1:0]             cfg_wait_hi,
    input  logic [$clog2(ADDR_W-DATA_W+1)-1:0] cfg_hi_width,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_ready,
    output logic [DATA_W-1:0]             req_rdata,
    output logic                          int_hit,
    output logic [DATA_W-1:0]             ad_o,
    output logic                          ad_oe,
    input  logic [DATA_W-1:0]             ad_i,
    output logic [ADDR_W-DATA_W-1:0]      hi_addr_o,
    output logic [ADDR_W-DATA_W-1:0]      hi_oe,
    output logic                          ale_o,
    output logic                          rd_n_o,
    output logic                          wr_n_o,
    output logic                          keeper_o
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int WID_W = $clog2(HI_W + 1);

    logic              is_ext;
    logic [WAIT_W-1:0] wait_code;
    logic [HI_W-1:0]   mask;
    logic [HI_W-1:0]   addr_hi;

    xbus_decode #(
        .ADDR_W(ADDR_W), .INT_TOP(INT_TOP), .SECT_SHIFT(SECT_SHIFT),
        .LIMIT_W(LIMIT_W), .WAIT_W(WAIT_W)
    ) i_decode (
        .addr(req_addr), .limit(cfg_limit), .wait_lo(cfg_wait_lo),
        .wait_hi(cfg_wait_hi), .compat(cfg_compat),
        .is_ext(is_ext), .wait_code(wait_code)
    );

    xbus_himask #(.HI_W(HI_W), .WID_W(WID_W)) i_himask (
        .enable(cfg_enable), .compat(cfg_compat), .width(cfg_hi_width), .mask(mask)
    );

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .is_ext(is_ext), .wait_code(wait_code),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ale(ale_o),
        .rd_n(rd_n_o), .wr_n(wr_n_o), .ready(req_ready), .rdata(req_rdata),
        .addr_hi(addr_hi)
    );

    assign int_hit   = req_valid && !is_ext;
    assign hi_oe     = mask;
    assign hi_addr_o = addr_hi & mask;
    assign keeper_o  = cfg_enable && !cfg_compat && cfg_keeper_en && !ad_oe;

    a_r8_released_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_oe & hi_addr_o) == hi_addr_o));
    a_r11_disabled_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (hi_oe == '0) && !keeper_o);
    a_r10_compat_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_compat) |-> (&hi_oe) && !keeper_o);
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
    logic clk = 0, rst_n = 0;
    logic cfg_enable = 1, cfg_compat = 0, cfg_keeper_en = 1;
    logic [2:0] cfg_limit = 0;
    logic [1:0] cfg_wait_lo = 0, cfg_wait_hi = 0;
    logic [3:0] cfg_hi_width = 8;
    logic req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0;
    logic [7:0] req_wdata = 0;
    logic req_ready, int_hit, ad_oe, ale_o, rd_n_o, wr_n_o, keeper_o;
    logic [7:0] req_rdata, ad_o, ad_i, hi_addr_o, hi_oe;
    logic [7:0] rd_val = 0;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    assign ad_i = rd_n_o ? ~rd_val : rd_val;

    xbus_ctrl i_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_compat(cfg_compat),
        .cfg_keeper_en(cfg_keeper_en), .cfg_limit(cfg_limit), .cfg_wait_lo(cfg_wait_lo),
        .cfg_wait_hi(cfg_wait_hi), .cfg_hi_width(cfg_hi_width), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .int_hit(int_hit), .ad_o(ad_o),
        .ad_oe(ad_oe), .ad_i(ad_i), .hi_addr_o(hi_addr_o), .hi_oe(hi_oe), .ale_o(ale_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .keeper_o(keeper_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] a, input bit w, input logic [7:0] wd);
        bit ext, en, lower, bad, kexp;
        int code, cyc, rdc, wrc, alec, exp_cyc, exp_str;
        logic [7:0] m, rexp;
        string why;
        en    = cfg_enable;
        ext   = a > 16'h10FF;
        lower = !cfg_compat && cfg_limit != 0 && a < (16'(cfg_limit) << 13);
        code  = cfg_compat ? int'(cfg_wait_hi[0]) : lower ? int'(cfg_wait_lo) : int'(cfg_wait_hi);
        m     = !en ? 8'h00 : (cfg_compat || cfg_hi_width >= 8) ? 8'hFF
                : 8'((9'd1 << cfg_hi_width) - 9'd1);
        kexp  = en && !cfg_compat && cfg_keeper_en;
        exp_cyc = !en ? 1 : ext ? 4 + code : 4;
        exp_str = (en && ext) ? 1 + code : 0;
        rd_val  = a[7:0] ^ a[15:8] ^ 8'h5A;
        rexp    = (en && ext && !w) ? rd_val : 8'h00;
        req_addr = a; req_write = w; req_wdata = wd; req_valid = 1;
        #1;
        chk(int_hit == !ext, "R1 internal hit", int_hit, !ext);
        cyc = 0; rdc = 0; wrc = 0; alec = 0; bad = 0; why = "";
        while (1) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (ale_o) alec++;
            if (!rd_n_o) rdc++;
            if (!wr_n_o) wrc++;
            if (hi_oe != m || hi_addr_o != (a[15:8] & m)) begin bad = 1; why = "R8 R3 high byte"; end
            if (en && cyc == 1 && !(ale_o && ad_oe && ad_o == a[7:0])) begin bad = 1; why = "R3 T1 address"; end
            if (cyc != 1 && ale_o) begin bad = 1; why = "R3 late ALE"; end
            if (en && w && cyc >= 2 && !(ad_oe && ad_o == wd)) begin bad = 1; why = "R4 write data"; end
            if (en && !w && cyc >= 2 && (ad_oe || ad_o != a[7:0])) begin bad = 1; why = "R5 R9 read bus"; end
            if (!ad_oe && keeper_o != kexp) begin bad = 1; why = "R9 R10 keeper"; end
            if (ext && en && (cyc >= 3 && cyc <= 2 + exp_str) != !(w ? wr_n_o : rd_n_o)) begin bad = 1; why = "R4 R5 strobe window"; end
            if (!en && (ad_oe || ale_o || !rd_n_o || !wr_n_o)) begin bad = 1; why = "R11 bus activity"; end
            if (req_ready || cyc > 12) break;
        end
        chk(!bad, why == "" ? "protocol" : why, bad, 0);
        chk(cyc == exp_cyc, "R2,R6,R12 ready period", cyc, exp_cyc);
        chk(rdc == (w ? 0 : exp_str), "R5,R7 read strobe clocks", rdc, w ? 0 : exp_str);
        chk(wrc == (w ? exp_str : 0), "R4,R7 write strobe clocks", wrc, w ? exp_str : 0);
        chk(alec == (en ? 1 : 0), "R3,R11 ALE pulses", alec, en ? 1 : 0);
        chk(req_rdata == rexp, "R5,R7,R11 read data", req_rdata, rexp);
        req_valid = 0;
        @(posedge clk); @(negedge clk);
        chk(!req_ready, "R2 ready one clock", req_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_ready && !ale_o && rd_n_o && wr_n_o && !ad_oe, "R2,R3 reset state", 0, 0);
        rst_n = 1;
        @(negedge clk);
        // R6 sector sweep: every limit against every code pair
        for (int lim = 0; lim < 8; lim++)
            for (int wl = 0; wl < 4; wl++)
                for (int wh = 0; wh < 4; wh++) begin
                    logic [15:0] bnd;
                    cfg_limit = 3'(lim); cfg_wait_lo = 2'(wl); cfg_wait_hi = 2'(wh);
                    bnd = (lim == 0) ? 16'h8000 : 16'(lim) << 13;
                    foreach (bnd[i]) if (i < 2) begin
                        bit w = (i == 1);
                        xfer(16'h10FF, w, 8'hC3);
                        xfer(16'h1100, w, 8'h3C);
                        xfer(bnd - 16'd1, w, 8'h96);
                        xfer(bnd, w, 8'h69);
                        xfer(16'hFFFF, w, 8'hA5);
                    end
                end
        xfer(16'h0000, 0, 8'h00);
        // R8 high width sweep, keeper off
        cfg_keeper_en = 0; cfg_limit = 0; cfg_wait_hi = 1;
        for (int wd = 0; wd < 10; wd++) begin
            cfg_hi_width = 4'(wd);
            xfer(16'hA5C3, 0, 8'h00);
            xfer(16'h5A3C, 1, 8'h7E);
        end
        // R10 compatibility mode
        cfg_compat = 1; cfg_keeper_en = 1; cfg_hi_width = 2; cfg_limit = 7;
        cfg_wait_lo = 3;
        for (int wh = 0; wh < 4; wh++) begin
            cfg_wait_hi = 2'(wh);
            xfer(16'h1234, 0, 8'h00);
            xfer(16'hF00D, 1, 8'h11);
        end
        // R11 disabled interface
        cfg_compat = 0; cfg_enable = 0; cfg_wait_hi = 3;
        xfer(16'h8000, 0, 8'h00);
        xfer(16'h8001, 1, 8'h22);
        xfer(16'h0100, 0, 8'h00);
        cfg_enable = 1;
        xfer(16'hC000, 0, 8'h00);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule